// File: doc/BRIEF.md
# Two-Core Mailbox with Hardware Lock

This peripheral lets two processors signal each other over a shared 32-bit register bus. It keeps one 32-bit message word for each destination core. A sender can load the whole word, or it can set or drop single bits through two write-only alias addresses, so that many flag bits can share one word. While a core's word holds any nonzero bit, that core's interrupt line stays high. The receiving core clears the bits it has handled, and the line falls when the word reaches zero.

A single lock bit protects shared resources. A read of the lock address acquires the lock in the same access: it returns 1 to the core that got the lock and 0 to any core that tried while the lock was held. A write with bit 0 set frees the lock.

The bus has an address, write and read strobes, write data and registered read data. Read data appears one cycle after the read strobe and holds until the next read. When the write and read strobes are both high, the access is a write.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset both message words are zero, both interrupt lines are low, and the first read of the lock returns 1.
- R2: A write to offset 0x00 (core 0) or 0x10 (core 1) replaces the whole word for that core, and a read at the same offset returns the word.
- R3: A write to offset 0x04 or 0x14 ORs the written bits into the word for core 0 or core 1.
- R4: A write to offset 0x08 or 0x18 clears, in the word for core 0 or core 1, every bit written as 1. Writing zero to either alias leaves the word unchanged.
- R5: Interrupt line i (bit i of `coreIrq`) is high, as a level, exactly while word i is nonzero. It follows a write on the next clock edge.
- R6: A read at 0xF8 returns 1 and takes the lock when the lock is free. When the lock is held, the read returns 0 and changes nothing.
- R7: A write at 0xF8 with bit 0 set frees the lock. A write there with bit 0 clear has no effect.
- R8: Slots 2 to 14 (0x20 to 0xEF), word 3 of each slot (for example 0x0C) and 0xF0 and 0xF4 read as zero, and writes to them change nothing.
- R9: Reads of the set and clear aliases return zero and do not change any word.
- R10: Read data is registered. It is valid on the edge after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 8 | Byte address of the access |
| busWe | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRe | input | 1 | Read strobe |
| busRdata | output | 32 | Registered read data |
| coreIrq | output | 2 | Interrupt level per destination core |

## Verification
The message words are exercised with full writes, with set patterns that overlap bits already present, with clear patterns that remove only some bits, and with all-zero alias writes. Each expected value shows whether the alias merges into the word or replaces it. Both words are loaded with distinct values, so a write that reaches the wrong core shows up when the other core's word is read back. The lock is read several times in a row, and released with bit 0 clear and then set, which shows whether acquisition happens only once and whether release depends on bit 0. Writes to unused and reserved addresses are followed by read-back of both words, so any hidden alias in the decode is caught.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int N_BOX  = 2;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;

  typedef struct packed {
    logic [N_BOX-1:0] wrData;
    logic [N_BOX-1:0] wrSet;
    logic [N_BOX-1:0] wrClr;
    logic [N_BOX-1:0] rdBox;
    logic             rdMutex;
    logic             relMutex;
    logic             rdZero;
  } strobe_t;
endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter logic [ADDR_W-1:0] MUTEX_ADDR = 8'hF8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic              relBit,
  output strobe_t           st
);
  localparam int SLOT_W = ADDR_W - 4;
  localparam int SPAN   = N_BOX * 16;

  logic [SLOT_W-1:0] slotIdx;
  logic [1:0]        wordIdx;
  logic              isMutex;

  assign slotIdx = busAddr[ADDR_W-1:4];
  assign wordIdx = busAddr[3:2];
  assign isMutex = (busAddr == MUTEX_ADDR);

  always_comb begin
    st = '0;
    if (busWe) begin
      if (isMutex) begin
        st.relMutex = relBit;
      end else begin
        for (int i = 0; i < N_BOX; i++) begin
          if (slotIdx == SLOT_W'(i)) begin
            case (wordIdx)
              2'd0:    st.wrData[i] = 1'b1;
              2'd1:    st.wrSet[i]  = 1'b1;
              2'd2:    st.wrClr[i]  = 1'b1;
              default: ;
            endcase
          end
        end
      end
    end else if (busRe) begin
      st.rdZero = 1'b1;
      if (isMutex) begin
        st.rdMutex = 1'b1;
        st.rdZero  = 1'b0;
      end else if (wordIdx == 2'd0) begin
        for (int i = 0; i < N_BOX; i++) begin
          if (slotIdx == SLOT_W'(i)) begin
            st.rdBox[i] = 1'b1;
            st.rdZero   = 1'b0;
          end
        end
      end
    end
  end

  // R8: at most one action per cycle
  a_r8_one_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.wrData, st.wrSet, st.wrClr, st.rdBox, st.rdMutex, st.relMutex, st.rdZero}));

  // R8: addresses beyond the implemented slots never reach a word
  a_r8_no_box_beyond: assert property (@(posedge clk) disable iff (!rstN)
    (int'(busAddr) >= SPAN) |-> (st.wrData == '0 && st.wrSet == '0 && st.wrClr == '0 && st.rdBox == '0));
endmodule

// File: rtl/mbox_dp.sv
module mbox_dp
  import mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [N_BOX-1:0]  coreIrq
);
  logic [DATA_W-1:0] boxReg [N_BOX];
  logic [DATA_W-1:0] boxMux;
  logic              mutexFree;

  for (genvar i = 0; i < N_BOX; i++) begin : g_box
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             boxReg[i] <= '0;
      else if (st.wrData[i]) boxReg[i] <= busWdata;
      else if (st.wrSet[i])  boxReg[i] <= boxReg[i] | busWdata;
      else if (st.wrClr[i])  boxReg[i] <= boxReg[i] & ~busWdata;
    end
    assign coreIrq[i] = |boxReg[i];

    a_r3_set_merges: assert property (@(posedge clk) disable iff (!rstN)
      st.wrSet[i] |=> ((boxReg[i] & $past(busWdata)) == $past(busWdata)));
    a_r4_clr_drops: assert property (@(posedge clk) disable iff (!rstN)
      st.wrClr[i] |=> ((boxReg[i] & $past(busWdata)) == '0));
    a_r5_irq_rises: assert property (@(posedge clk) disable iff (!rstN)
      (st.wrData[i] && busWdata != '0) |=> coreIrq[i]);
    a_r5_irq_falls: assert property (@(posedge clk) disable iff (!rstN)
      (st.wrData[i] && busWdata == '0) |=> !coreIrq[i]);
  end

  always_comb begin
    boxMux = '0;
    for (int i = 0; i < N_BOX; i++)
      if (st.rdBox[i]) boxMux = boxMux | boxReg[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            mutexFree <= 1'b1;
    else if (st.relMutex) mutexFree <= 1'b1;
    else if (st.rdMutex)  mutexFree <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               busRdata <= '0;
    else if (|st.rdBox)      busRdata <= boxMux;
    else if (st.rdMutex)     busRdata <= DATA_W'(mutexFree);
    else if (st.rdZero)      busRdata <= '0;
  end

  a_r6_grant: assert property (@(posedge clk) disable iff (!rstN)
    (st.rdMutex && mutexFree) |=> (busRdata == DATA_W'(1) && !mutexFree));
  a_r6_refuse: assert property (@(posedge clk) disable iff (!rstN)
    (st.rdMutex && !mutexFree) |=> (busRdata == '0 && !mutexFree));
  a_r7_release: assert property (@(posedge clk) disable iff (!rstN)
    st.relMutex |=> mutexFree);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(st.rdZero || st.rdMutex || (|st.rdBox)) |=> $stable(busRdata));
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import mbox_pkg::*;
#(
  parameter logic [ADDR_W-1:0] MUTEX_ADDR = 8'hF8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busRe,
  output logic [DATA_W-1:0] busRdata,
  output logic [N_BOX-1:0]  coreIrq
);
  strobe_t st;

  mbox_ctrl #(.MUTEX_ADDR(MUTEX_ADDR)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWe   (busWe),
    .busRe   (busRe),
    .relBit  (busWdata[0]),
    .st      (st)
  );

  mbox_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .coreIrq  (coreIrq)
  );
endmodule

// File: tb/ipc_mailbox_tb.sv
module ipc_mailbox_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic        busRe = 1'b0;
  logic [31:0] busRdata;
  logic [1:0]  coreIrq;

  int checks = 0;
  int failures = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];
  bit          done = 1'b0;

  always #2 clk = ~clk;

  ipc_mailbox u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRe(busRe), .busRdata(busRdata), .coreIrq(coreIrq)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic doRead(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    busAddr = a; busRe = 1'b1;
    expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk);
    busRe = 1'b0;
  endtask

  // monitor: pops expected read data
  initial begin
    forever begin
      @(posedge clk);
      if (busRe && !busWe) begin
        @(negedge clk);
        if (expQ.size() == 0) check(busRdata, 32'hx, "QUEUE");
        else check(busRdata, expQ.pop_front(), tagQ.pop_front());
      end
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check({30'b0, coreIrq}, 32'h0, "R1 irq after reset");
    doRead(8'h00, 32'h0, "R1 box0 reset");
    doRead(8'h10, 32'h0, "R1 box1 reset");
    doRead(8'hF8, 32'h1, "R1 lock free");
    doWrite(8'hF8, 32'h1);

    doWrite(8'h00, 32'hA5A5_0000);
    check({30'b0, coreIrq}, 32'h1, "R5 irq0 only");
    doRead(8'h00, 32'hA5A5_0000, "R2 box0 write");
    doWrite(8'h04, 32'h0000_01FF);
    doRead(8'h00, 32'hA5A5_01FF, "R3 set merge");
    doWrite(8'h04, 32'h0);
    doRead(8'h00, 32'hA5A5_01FF, "R4 zero set no change");
    doWrite(8'h08, 32'h0);
    doRead(8'h00, 32'hA5A5_01FF, "R4 zero clr no change");
    doWrite(8'h08, 32'hA5A5_01F0);
    doRead(8'h00, 32'h0000_000F, "R4 clr partial");
    check({30'b0, coreIrq}, 32'h1, "R5 irq0 still high");
    doWrite(8'h08, 32'h0000_000F);
    check({30'b0, coreIrq}, 32'h0, "R5 irq0 falls");

    doWrite(8'h14, 32'h8000_0001);
    check({30'b0, coreIrq}, 32'h2, "R5 irq1 only");
    doRead(8'h10, 32'h8000_0001, "R3 box1 set");
    doRead(8'h00, 32'h0, "R2 box0 untouched");
    doWrite(8'h10, 32'h0);
    check({30'b0, coreIrq}, 32'h0, "R2 direct zero");
    doWrite(8'h10, 32'h0000_1234);
    doWrite(8'h00, 32'h0000_00C3);
    check({30'b0, coreIrq}, 32'h3, "R5 both irq");

    doWrite(8'h20, 32'hFFFF_FFFF);
    doWrite(8'h24, 32'hFFFF_FFFF);
    doWrite(8'h28, 32'hFFFF_FFFF);
    doWrite(8'hE8, 32'hFFFF_FFFF);
    doWrite(8'h0C, 32'hFFFF_FFFF);
    doWrite(8'h1C, 32'hFFFF_FFFF);
    doWrite(8'hF0, 32'hFFFF_FFFF);
    doWrite(8'hF4, 32'hFFFF_FFFF);
    doRead(8'h20, 32'h0, "R8 slot2 zero");
    doRead(8'hE0, 32'h0, "R8 slot14 zero");
    doRead(8'h0C, 32'h0, "R8 word3 zero");
    doRead(8'hF0, 32'h0, "R8 reserved F0");
    doRead(8'hF4, 32'h0, "R8 reserved F4");
    doRead(8'h00, 32'h0000_00C3, "R8 box0 intact");
    doRead(8'h10, 32'h0000_1234, "R8 box1 intact");

    doRead(8'h04, 32'h0, "R9 set alias read");
    doRead(8'h18, 32'h0, "R9 clr alias read");
    doRead(8'h08, 32'h0, "R9 clr alias read 0");
    doRead(8'h10, 32'h0000_1234, "R9 box1 no side effect");
    doRead(8'h00, 32'h0000_00C3, "R9 box0 no side effect");

    doRead(8'hF8, 32'h1, "R6 acquire");
    doRead(8'hF8, 32'h0, "R6 held");
    doRead(8'hF8, 32'h0, "R6 held again");
    doWrite(8'hF8, 32'hFFFF_FFFE);
    doRead(8'hF8, 32'h0, "R7 bit0 clear ignored");
    doWrite(8'hF8, 32'h1);
    doRead(8'hF8, 32'h1, "R7 released");
    doRead(8'hF8, 32'h0, "R7 retaken");

    doRead(8'h10, 32'h0000_1234, "R10 read");
    repeat (3) @(negedge clk);
    check(busRdata, 32'h0000_1234, "R10 hold");
    doWrite(8'h10, 32'h5);
    check(busRdata, 32'h0000_1234, "R10 hold over write");

    repeat (3) @(negedge clk);
    check(expQ.size(), 0, "queue drained");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule